// File: doc/BRIEF.md
# Hashed Indirect Branch Target Cache

This block predicts where an indirect branch will go. It is a set-associative table in which every way holds a valid bit, a tag taken from the branch address, and a full target address. A fetch-side lookup supplies the branch PC, a global history value and a short list of the most recent indirect targets. It gets back, in the same cycle, a hit flag and the stored target. When a branch resolves, an update supplies the same kind of index inputs and the correct target. The table then either refreshes the way that already holds that branch or allocates a way for it.

The set index starts from the word-aligned PC. Two compile-time switches let it also fold in the global history and the recent-target list. Each history slot is shifted by a different amount before the XOR, so that the same address seen at different ages lands on different index bits. An update input drops the youngest history slot, so that a branch being corrected is indexed without its own entry. When a set is full, allocation falls back on a free-running pseudo-random generator.

Top module: `ind_tgt_cache`

## Requirements
- R1: After reset every way is invalid, so every lookup reports a miss until an update has written that set.
- R2: On a miss `lk_hit` is 0 and `lk_target` is all zeros; on a hit `lk_target` is the target stored in the matching way.
- R3: The tag is `(pc >> ISHIFT)` truncated to its low TAG_W bits; a hit needs a valid way in the indexed set whose tag equals it, so two PCs that agree in index and tag share one entry.
- R4: The set index is `(pc >> ISHIFT)`, XORed with the zero-extended global history when HASH_GHR is 1, reduced to its low log2(SETS) bits.
- R5: When HASH_PATH is 1, history slot p (bits [p*ADDR_W +: ADDR_W] of the path bus, slot 0 the youngest) is shifted right by ISHIFT + p*STEP and XORed into the index, where STEP = floor(log2(SETS)/PATH_LEN). Only the first `cnt` slots take part, and a count above PATH_LEN acts as PATH_LEN.
- R6: When `up_skip_young` is 1, slot 0 of the update path bus is ignored: slot p+1 takes the place and shift of slot p and the count is reduced by one (not below zero).
- R7: An update whose tag matches a valid way in its set overwrites only that way's target; the other ways of the set keep their contents.
- R8: An update with no tag match writes tag and target into the lowest-numbered invalid way of the set, or, if the set is full, into the way given by a free-running 16-bit LFSR modulo WAYS.
- R9: An update is written on the clock edge: a lookup of the same entry in the same cycle sees the contents from before the update, and a lookup in the following cycle sees the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | ADDR_W | Branch address to predict |
| lk_ghr | input | GHR_W | Global history for the lookup |
| lk_path | input | PATH_LEN*ADDR_W | Recent indirect targets, slot 0 youngest, in the low bits |
| lk_path_cnt | input | CNT_W | Number of valid slots in `lk_path` |
| lk_hit | output | 1 | Lookup found a valid matching way |
| lk_target | output | ADDR_W | Predicted target, zero on a miss |
| up_valid | input | 1 | Write an update this cycle |
| up_pc | input | ADDR_W | Resolved branch address |
| up_ghr | input | GHR_W | Global history used for the update index |
| up_path | input | PATH_LEN*ADDR_W | Recent indirect targets for the update index |
| up_path_cnt | input | CNT_W | Number of valid slots in `up_path` |
| up_skip_young | input | 1 | Drop slot 0 of `up_path` from the index |
| up_target | input | ADDR_W | Correct target to store |

## Verification
The bench builds the cache with 8 sets, 2 ways, an 8-bit tag, a 16-bit address, an 8-bit history and a path length of 2, with both hashing switches on. That gives a history step of one bit, so slot 0 and slot 1 enter at shifts 2 and 3, and a hand-picked history value can be seen to land in the same set as a path entry. With only two ways per set, three branches chosen for one set are enough to fill it and force a random eviction. With a 16-bit address, PCs that differ only above the tag alias onto one entry.

// File: rtl/itc_pkg.sv
package itc_pkg;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // Per-slot extra shift used when folding path history into the index.
  function automatic int unsigned path_step(input int unsigned idx_bits,
                                            input int unsigned plen);
    return (plen == 0) ? 0 : idx_bits / plen;
  endfunction

endpackage

// File: rtl/itc_lfsr.sv
module itc_lfsr #(
  parameter int unsigned W = itc_pkg::LFSR_W,
  parameter logic [W-1:0] SEED = itc_pkg::LFSR_SEED,
  parameter logic [W-1:0] TAPS = itc_pkg::LFSR_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic [W-1:0] state_d;

  always_comb begin
    state_d = state >> 1;
    if (state[0]) state_d = (state >> 1) ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end

endmodule

// File: rtl/itc_index_hash.sv
module itc_index_hash #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GHR_W     = 16,
  parameter int unsigned PATH_LEN  = 3,
  parameter int unsigned ISHIFT    = 2,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CNT_W     = 2,
  parameter bit          HASH_GHR  = 1'b1,
  parameter bit          HASH_PATH = 1'b1
) (
  input  logic [ADDR_W-1:0]          pc,
  input  logic [GHR_W-1:0]           ghr,
  input  logic [PATH_LEN*ADDR_W-1:0] path,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       skip,
  output logic [IDX_W-1:0]           idx
);

  localparam int unsigned STEP = itc_pkg::path_step(IDX_W, PATH_LEN);

  logic [ADDR_W-1:0] slot [PATH_LEN+1];
  logic [ADDR_W-1:0] acc;
  int                avail;

  always_comb begin
    for (int p = 0; p < PATH_LEN; p++) slot[p] = path[p*ADDR_W +: ADDR_W];
    slot[PATH_LEN] = '0;

    avail = int'(cnt);
    if (avail > int'(PATH_LEN)) avail = int'(PATH_LEN);
    if (skip && avail > 0) avail = avail - 1;

    acc = pc >> ISHIFT;
    if (HASH_GHR) acc = acc ^ ADDR_W'(ghr);
    if (HASH_PATH) begin
      for (int p = 0; p < PATH_LEN; p++) begin
        if (p < avail) begin
          if (skip) acc = acc ^ (slot[p+1] >> (ISHIFT + p*STEP));
          else      acc = acc ^ (slot[p]   >> (ISHIFT + p*STEP));
        end
      end
    end
    idx = acc[IDX_W-1:0];
  end

endmodule

// File: rtl/itc_way.sv
module itc_way #(
  parameter int unsigned SETS   = 256,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 16,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port A (lookup)
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_vld,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  // read port B (update match)
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_vld,
  output logic [TAG_W-1:0]  rb_tag,
  // write port
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [ADDR_W-1:0] w_tgt
);

  logic [SETS-1:0]   vld_q;
  logic [SETS-1:0]   vld_d;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [ADDR_W-1:0] tgt_mem [SETS];

  always_comb begin
    vld_d = vld_q;
    if (we) vld_d[w_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= w_tgt;
    end
  end

  assign ra_vld = vld_q[ra_idx];
  assign ra_tag = tag_mem[ra_idx];
  assign ra_tgt = tgt_mem[ra_idx];
  assign rb_vld = vld_q[rb_idx];
  assign rb_tag = tag_mem[rb_idx];

endmodule

// File: rtl/ind_tgt_cache.sv
module ind_tgt_cache #(
  parameter int unsigned SETS      = 256,
  parameter int unsigned WAYS      = 2,
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned PATH_LEN  = 3,
  parameter int unsigned ISHIFT    = 2,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GHR_W     = 16,
  parameter bit          HASH_GHR  = 1'b1,
  parameter bit          HASH_PATH = 1'b1,
  localparam int unsigned CNT_W    = (PATH_LEN > 1) ? $clog2(PATH_LEN + 1) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          lk_pc,
  input  logic [GHR_W-1:0]           lk_ghr,
  input  logic [PATH_LEN*ADDR_W-1:0] lk_path,
  input  logic [CNT_W-1:0]           lk_path_cnt,
  output logic                       lk_hit,
  output logic [ADDR_W-1:0]          lk_target,
  input  logic                       up_valid,
  input  logic [ADDR_W-1:0]          up_pc,
  input  logic [GHR_W-1:0]           up_ghr,
  input  logic [PATH_LEN*ADDR_W-1:0] up_path,
  input  logic [CNT_W-1:0]           up_path_cnt,
  input  logic                       up_skip_young,
  input  logic [ADDR_W-1:0]          up_target
);

  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned LFSR_W = itc_pkg::LFSR_W;

  // elaboration-time geometry checks
  if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
    $error("ind_tgt_cache: SETS must be a power of two, at least 2");
  end
  if (PATH_LEN < 1) begin : g_bad_path
    $error("ind_tgt_cache: PATH_LEN must be at least 1");
  end
  if (GHR_W > ADDR_W || TAG_W + ISHIFT > ADDR_W) begin : g_bad_width
    $error("ind_tgt_cache: history or tag wider than the address allows");
  end

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // index and tag generation
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [TAG_W-1:0] up_tag;

  assign lk_tag = TAG_W'(lk_pc >> ISHIFT);
  assign up_tag = TAG_W'(up_pc >> ISHIFT);

  itc_index_hash #(
    .ADDR_W(ADDR_W), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN), .ISHIFT(ISHIFT),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .HASH_GHR(HASH_GHR), .HASH_PATH(HASH_PATH)
  ) u_lk_hash (
    .pc(lk_pc), .ghr(lk_ghr), .path(lk_path), .cnt(lk_path_cnt),
    .skip(1'b0), .idx(lk_idx)
  );

  itc_index_hash #(
    .ADDR_W(ADDR_W), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN), .ISHIFT(ISHIFT),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .HASH_GHR(HASH_GHR), .HASH_PATH(HASH_PATH)
  ) u_up_hash (
    .pc(up_pc), .ghr(up_ghr), .path(up_path), .cnt(up_path_cnt),
    .skip(up_skip_young), .idx(up_idx)
  );

  // way storage
  logic [WAYS-1:0]   lk_vld;
  logic [WAYS-1:0]   up_vld;
  logic [TAG_W-1:0]  lk_tagr [WAYS];
  logic [TAG_W-1:0]  up_tagr [WAYS];
  logic [ADDR_W-1:0] lk_tgtr [WAYS];
  logic [WAYS-1:0]   way_we;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    itc_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
    ) u_way (
      .clk(clk), .rst_n(core_rst_n),
      .ra_idx(lk_idx), .ra_vld(lk_vld[w]), .ra_tag(lk_tagr[w]), .ra_tgt(lk_tgtr[w]),
      .rb_idx(up_idx), .rb_vld(up_vld[w]), .rb_tag(up_tagr[w]),
      .we(way_we[w]), .w_idx(up_idx), .w_tag(up_tag), .w_tgt(up_target)
    );
  end

  // lookup: combinational from registered storage
  logic [WAYS-1:0] lk_hv;

  always_comb begin
    lk_target = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_hv[w] = lk_vld[w] && (lk_tagr[w] == lk_tag);
      if (lk_hv[w]) lk_target = lk_target | lk_tgtr[w];
    end
    lk_hit = |lk_hv;
  end

  // update: refresh a match, else fill a free way, else a random one
  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  victim_rnd;
  logic [WAYS-1:0]   up_hv;
  logic [WAY_W-1:0]  match_way;
  logic [WAY_W-1:0]  free_way;
  logic              any_free;
  logic [WAY_W-1:0]  sel_way;

  itc_lfsr u_lfsr (
    .clk(clk), .rst_n(core_rst_n), .state(lfsr_q)
  );

  assign victim_rnd = WAY_W'(lfsr_q % LFSR_W'(WAYS));

  always_comb begin
    match_way = '0;
    free_way  = '0;
    any_free  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      up_hv[w] = up_vld[w] && (up_tagr[w] == up_tag);
      if (up_hv[w]) match_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!up_vld[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    if (|up_hv)        sel_way = match_way;
    else if (any_free) sel_way = free_way;
    else               sel_way = victim_rnd;
    for (int w = 0; w < WAYS; w++) begin
      way_we[w] = up_valid && core_rst_n && (sel_way == WAY_W'(w));
    end
  end

endmodule

// File: rtl/ind_tgt_cache_chk.sv
module ind_tgt_cache_chk #(
  parameter int unsigned WAYS     = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GHR_W    = 16,
  parameter int unsigned PATH_LEN = 3,
  parameter int unsigned CNT_W    = 2,
  parameter int unsigned LFSR_W   = 16
) (
  input logic                       clk,
  input logic                       core_rst_n,
  input logic [ADDR_W-1:0]          lk_pc,
  input logic [GHR_W-1:0]           lk_ghr,
  input logic [PATH_LEN*ADDR_W-1:0] lk_path,
  input logic [CNT_W-1:0]           lk_path_cnt,
  input logic                       lk_hit,
  input logic [ADDR_W-1:0]          lk_target,
  input logic                       up_valid,
  input logic [ADDR_W-1:0]          up_pc,
  input logic [GHR_W-1:0]           up_ghr,
  input logic [PATH_LEN*ADDR_W-1:0] up_path,
  input logic [CNT_W-1:0]           up_path_cnt,
  input logic                       up_skip_young,
  input logic [ADDR_W-1:0]          up_target,
  input logic [WAYS-1:0]            lk_hv,
  input logic [WAYS-1:0]            up_hv,
  input logic [LFSR_W-1:0]          lfsr_q
);

  logic armed;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  // R1: first cycle out of reset, nothing can hit
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!core_rst_n)
    !armed |-> !lk_hit);

  // R2: a miss drives a zero target
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
    !lk_hit |-> (lk_target == '0));

  // R7: updates never leave two matching ways in one set
  a_r7_single_match: assert property (@(posedge clk) disable iff (!core_rst_n)
    $onehot0(lk_hv) && $onehot0(up_hv));

  // R8: the random source never locks up and keeps moving
  a_r8_lfsr_moves: assert property (@(posedge clk) disable iff (!core_rst_n)
    armed |-> (lfsr_q != '0) && (lfsr_q != $past(lfsr_q)));

  // R9: an entry written last cycle is visible to an identical lookup
  a_r9_next_cycle_visible: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && $past(up_valid) && !$past(up_skip_young) &&
     lk_pc == $past(up_pc) && lk_ghr == $past(up_ghr) &&
     lk_path == $past(up_path) && lk_path_cnt == $past(up_path_cnt))
    |-> (lk_hit && lk_target == $past(up_target)));

endmodule

bind ind_tgt_cache ind_tgt_cache_chk #(
  .WAYS(WAYS), .ADDR_W(ADDR_W), .GHR_W(GHR_W), .PATH_LEN(PATH_LEN),
  .CNT_W(CNT_W), .LFSR_W(LFSR_W)
) u_chk (
  .clk(clk), .core_rst_n(core_rst_n),
  .lk_pc(lk_pc), .lk_ghr(lk_ghr), .lk_path(lk_path), .lk_path_cnt(lk_path_cnt),
  .lk_hit(lk_hit), .lk_target(lk_target),
  .up_valid(up_valid), .up_pc(up_pc), .up_ghr(up_ghr), .up_path(up_path),
  .up_path_cnt(up_path_cnt), .up_skip_young(up_skip_young), .up_target(up_target),
  .lk_hv(lk_hv), .up_hv(up_hv), .lfsr_q(lfsr_q)
);

// File: tb/ind_tgt_cache_test.sv
module ind_tgt_cache_test;

  localparam int unsigned SETS = 8, WAYS = 2, TAG_W = 8, PATH_LEN = 2;
  localparam int unsigned ISHIFT = 2, ADDR_W = 16, GHR_W = 8, CNT_W = 2;

  logic                       clk = 1'b0;
  logic                       rst_n;
  logic [ADDR_W-1:0]          lk_pc, up_pc, up_target, lk_target;
  logic [GHR_W-1:0]           lk_ghr, up_ghr;
  logic [PATH_LEN*ADDR_W-1:0] lk_path, up_path;
  logic [CNT_W-1:0]           lk_path_cnt, up_path_cnt;
  logic                       lk_hit, up_valid, up_skip_young;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  logic              r_hit;
  logic [ADDR_W-1:0] r_tgt;

  always #5 clk = ~clk;

  ind_tgt_cache #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PATH_LEN(PATH_LEN),
    .ISHIFT(ISHIFT), .ADDR_W(ADDR_W), .GHR_W(GHR_W)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_ghr(lk_ghr), .lk_path(lk_path), .lk_path_cnt(lk_path_cnt),
    .lk_hit(lk_hit), .lk_target(lk_target),
    .up_valid(up_valid), .up_pc(up_pc), .up_ghr(up_ghr), .up_path(up_path),
    .up_path_cnt(up_path_cnt), .up_skip_young(up_skip_young), .up_target(up_target)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [15:0] pc, input logic [7:0] ghr,
                        input logic [15:0] p0, input logic [15:0] p1,
                        input logic [1:0] cnt);
    @(negedge clk);
    lk_pc = pc; lk_ghr = ghr; lk_path = {p1, p0}; lk_path_cnt = cnt;
    #1;
    r_hit = lk_hit;
    r_tgt = lk_target;
  endtask

  task automatic update(input logic [15:0] pc, input logic [7:0] ghr,
                        input logic [15:0] p0, input logic [15:0] p1,
                        input logic [1:0] cnt, input logic skip,
                        input logic [15:0] tgt);
    @(negedge clk);
    up_valid = 1'b1; up_pc = pc; up_ghr = ghr; up_path = {p1, p0};
    up_path_cnt = cnt; up_skip_young = skip; up_target = tgt;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [15:0] tgt);
    check(r_hit === 1'b1, req, 32'(r_hit), 32'd1);
    check(r_tgt === tgt, req, 32'(r_tgt), 32'(tgt));
  endtask

  task automatic expect_miss(input string req);
    check(r_hit === 1'b0, req, 32'(r_hit), 32'd0);
    check(r_tgt === 16'h0, req, 32'(r_tgt), 32'd0);
  endtask

  task automatic t_reset();
    lookup(16'h0040, 8'h00, 16'h0, 16'h0, 2'd0); expect_miss("R1 empty");
    lookup(16'h1234, 8'h5A, 16'h4, 16'h8, 2'd2); expect_miss("R1 R2 empty");
  endtask

  task automatic t_alloc_and_tag();
    update(16'h0040, 8'h00, 16'h0, 16'h0, 2'd0, 1'b0, 16'h1234);
    lookup(16'h0040, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R8 alloc", 16'h1234);
    lookup(16'h0044, 8'h00, 16'h0, 16'h0, 2'd0); expect_miss("R2 other set");
    // R3: bits above the tag are ignored, so 0x0440 aliases 0x0040
    lookup(16'h0440, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R3 alias", 16'h1234);
    // R3: same set, different tag
    lookup(16'h0060, 8'h00, 16'h0, 16'h0, 2'd0); expect_miss("R3 tag differs");
  endtask

  task automatic t_ghr();
    lookup(16'h0040, 8'h01, 16'h0, 16'h0, 2'd0); expect_miss("R4 ghr moves set");
    update(16'h0040, 8'h05, 16'h0, 16'h0, 2'd0, 1'b0, 16'h2222);
    lookup(16'h0040, 8'h05, 16'h0, 16'h0, 2'd0); expect_hit("R4 ghr set", 16'h2222);
    lookup(16'h0040, 8'h0D, 16'h0, 16'h0, 2'd0); expect_hit("R4 mask", 16'h2222);
    lookup(16'h0040, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R4 base kept", 16'h1234);
  endtask

  task automatic t_path();
    update(16'h0080, 8'h00, 16'h0004, 16'h0010, 2'd2, 1'b0, 16'h3333);
    lookup(16'h0080, 8'h00, 16'h0004, 16'h0010, 2'd2); expect_hit("R5 same path", 16'h3333);
    lookup(16'h0080, 8'h03, 16'h0, 16'h0, 2'd0);       expect_hit("R5 shifts", 16'h3333);
    lookup(16'h0080, 8'h00, 16'h0004, 16'h0010, 2'd1); expect_miss("R5 count");
    lookup(16'h0080, 8'h00, 16'h0004, 16'h0010, 2'd3); expect_hit("R5 clip", 16'h3333);
    lookup(16'h0080, 8'h00, 16'h0008, 16'h0008, 2'd2); expect_hit("R5 per slot", 16'h3333);
  endtask

  task automatic t_skip();
    update(16'h00C0, 8'h00, 16'h001C, 16'h0008, 2'd2, 1'b1, 16'h4444);
    lookup(16'h00C0, 8'h00, 16'h0008, 16'h0000, 2'd1); expect_hit("R6 skip young", 16'h4444);
    lookup(16'h00C0, 8'h00, 16'h001C, 16'h0008, 2'd2); expect_miss("R6 full path");
  endtask

  task automatic t_overwrite_evict();
    int hits;
    update(16'h0010, 8'h00, 16'h0, 16'h0, 2'd0, 1'b0, 16'h5001);
    update(16'h0030, 8'h00, 16'h0, 16'h0, 2'd0, 1'b0, 16'h5002);
    lookup(16'h0010, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R8 free way A", 16'h5001);
    lookup(16'h0030, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R8 free way B", 16'h5002);
    update(16'h0010, 8'h00, 16'h0, 16'h0, 2'd0, 1'b0, 16'h5003);
    lookup(16'h0010, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R7 refreshed", 16'h5003);
    lookup(16'h0030, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R7 neighbour kept", 16'h5002);
    update(16'h0050, 8'h00, 16'h0, 16'h0, 2'd0, 1'b0, 16'h5004);
    lookup(16'h0050, 8'h00, 16'h0, 16'h0, 2'd0); expect_hit("R8 evict alloc", 16'h5004);
    hits = 0;
    lookup(16'h0010, 8'h00, 16'h0, 16'h0, 2'd0);
    if (r_hit) hits++;
    lookup(16'h0030, 8'h00, 16'h0, 16'h0, 2'd0);
    if (r_hit) hits++;
    check(hits == 1, "R8 one survivor", 32'(hits), 32'd1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_pc = 16'h0018; lk_ghr = 8'h00; lk_path = '0; lk_path_cnt = 2'd0;
    up_valid = 1'b1; up_pc = 16'h0018; up_ghr = 8'h00; up_path = '0;
    up_path_cnt = 2'd0; up_skip_young = 1'b0; up_target = 16'h6006;
    #1;
    check(lk_hit === 1'b0, "R9 old before edge", 32'(lk_hit), 32'd0);
    @(negedge clk);
    up_target = 16'h6007;
    #1;
    check(lk_hit === 1'b1 && lk_target === 16'h6006, "R9 new after edge",
          32'(lk_target), 32'h6006);
    @(negedge clk);
    up_valid = 1'b0;
    #1;
    check(lk_target === 16'h6007, "R9 second write", 32'(lk_target), 32'h6007);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    up_valid = 1'b0; up_pc = '0; up_ghr = '0; up_path = '0; up_path_cnt = '0;
    up_skip_young = 1'b0; up_target = '0;
    lk_pc = '0; lk_ghr = '0; lk_path = '0; lk_path_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_alloc_and_tag();
    t_ghr();
    t_path();
    t_skip();
    t_overwrite_evict();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule